// File: doc/BRIEF.md
# Circular Descriptor Chain Loader

This block walks a ring of transfer descriptors held in memory and hands them, one at a time, to a DMA channel. A start pulse captures a head pointer. The loader then reads a four-word descriptor from that address through a simple read port that can take any number of cycles per word. Once the descriptor is complete, the loader presents it to the channel as a loaded configuration. It holds that configuration until the channel reports that the transaction is complete, and then follows the descriptor's link word to the next descriptor.

The ring is closed: the final descriptor links back to the head. The loader uses that return to the head as its end marker. It pulses a list-done output and stops, so it never fetches a stale entry. A descriptor whose length word is zero is treated as a configuration fault. It halts the walk and sets an error flag. A separate combinational path gives the channel its next transfer address. The address normally advances by a fixed step, and it jumps to a programmed target when it meets a programmed wrap point.

Top module: `ll_desc_loader`

## Requirements
- R1: After reset, mem_req, cfg_valid, list_done and cfg_err are all 0.
- R2: A start pulse while idle captures head_ptr. Each descriptor is then read as four words at consecutive addresses ptr+0, ptr+1, ptr+2 and ptr+3. Those words are, in order, source address, destination address, length and link pointer. The address and link fields are the low ADDR_W bits of their words, and the length field is the low LEN_W bits of its word. While mem_req is high and mem_rvalid is low, mem_addr does not change.
- R3: After all four words are received and the length is nonzero, cfg_src, cfg_dst and cfg_len present the descriptor and cfg_valid is high. cfg_valid stays high until xfer_done is seen, then falls on the next cycle. mem_req is never high while cfg_valid is high.
- R4: After xfer_done, if the link pointer differs from the captured head, the next descriptor is fetched from the link pointer.
- R5: After xfer_done, if the link pointer equals the captured head, list_done is high for exactly one cycle. No further read is issued and cfg_valid stays low.
- R6: A descriptor with length zero is never presented. Instead cfg_err goes high, the walk stops without list_done, and no further read is made. cfg_err returns to 0 on the next accepted start.
- R7: A start pulse while the walk is in progress has no effect.
- R8: xfer_done has no effect unless cfg_valid is high.
- R9: xfer_addr_next equals wrap_to when xfer_addr equals wrap_addr. Otherwise it equals xfer_addr + ADDR_STEP, modulo 2^ADDR_W.
- R10: While cfg_valid is high, cfg_src, cfg_dst and cfg_len do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking the ring (accepted only when idle) |
| head_ptr | input | ADDR_W | Address of the first descriptor |
| wrap_addr | input | ADDR_W | Transfer address at which the address jumps |
| wrap_to | input | ADDR_W | Address taken after the wrap point |
| xfer_addr | input | ADDR_W | Channel's current transfer address |
| xfer_addr_next | output | ADDR_W | Channel's next transfer address |
| mem_req | output | 1 | Read request, held until served |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| cfg_valid | output | 1 | Loaded configuration is active |
| cfg_src | output | ADDR_W | Loaded source address |
| cfg_dst | output | ADDR_W | Loaded destination address |
| cfg_len | output | LEN_W | Loaded length |
| xfer_done | input | 1 | Channel finished the active transaction |
| list_done | output | 1 | One-cycle pulse when the ring is complete |
| cfg_err | output | 1 | Zero-length descriptor found |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=32, LEN_W=16 and ADDR_STEP=4. The 32-bit words carry random upper bits that the loader must drop. The step of four makes a wrong increment easy to see. The bench places rings of one to eight descriptors at shuffled word addresses in a 256-word memory and returns each read after a random delay. A zero-length entry can be placed at the head or in the middle of a ring. The 16-bit address space lets the wrap path be checked at the top of the range, where the step overflows.

// File: rtl/ll_desc_pkg.sv
package ll_desc_pkg;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

  // Word slot within one descriptor; order is the read order.
  localparam logic [IDX_W-1:0] SLOT_SRC  = 2'd0;
  localparam logic [IDX_W-1:0] SLOT_DST  = 2'd1;
  localparam logic [IDX_W-1:0] SLOT_LEN  = 2'd2;
  localparam logic [IDX_W-1:0] SLOT_LINK = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_RUN,
    ST_NEXT
  } ld_state_e;
endpackage

// File: rtl/ll_addr_wrap.sv
module ll_addr_wrap #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ADDR_STEP = 1
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] wrap_at,
  input  logic [ADDR_W-1:0] wrap_dest,
  output logic [ADDR_W-1:0] nxt
);
  function automatic logic [ADDR_W-1:0] advance(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] w,
    input logic [ADDR_W-1:0] t
  );
    if (a == w) return t;
    return a + ADDR_W'(ADDR_STEP);
  endfunction

  assign nxt = advance(cur, wrap_at, wrap_dest);
endmodule

// File: rtl/ll_desc_regs.sv
module ll_desc_regs
  import ll_desc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_accept,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] word_data,
  input  logic              load_now,
  output logic [ADDR_W-1:0] stage_link,
  output logic              stage_len_zero,
  output logic [ADDR_W-1:0] cfg_src,
  output logic [ADDR_W-1:0] cfg_dst,
  output logic [LEN_W-1:0]  cfg_len
);
  logic [DATA_W-1:0] stage [DESC_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC_WORDS; i++) stage[i] <= '0;
    end else if (word_accept) begin
      stage[word_idx] <= word_data;
    end
  end

  assign stage_link     = stage[SLOT_LINK][ADDR_W-1:0];
  assign stage_len_zero = (stage[SLOT_LEN][LEN_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_src <= '0;
      cfg_dst <= '0;
      cfg_len <= '0;
    end else if (load_now) begin
      cfg_src <= stage[SLOT_SRC][ADDR_W-1:0];
      cfg_dst <= stage[SLOT_DST][ADDR_W-1:0];
      cfg_len <= stage[SLOT_LEN][LEN_W-1:0];
    end
  end
endmodule

// File: rtl/ll_fetch_fsm.sv
module ll_fetch_fsm
  import ll_desc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_ptr,
  input  logic              mem_rvalid,
  input  logic              xfer_done,
  input  logic              len_zero,
  input  logic [ADDR_W-1:0] link_ptr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              word_accept,
  output logic              load_now,
  output logic              running,
  output logic              ring_end,
  output logic              cfg_err
);
  ld_state_e         state;
  logic [ADDR_W-1:0] cur_ptr;
  logic [ADDR_W-1:0] head_q;
  logic              link_is_head;

  function automatic logic [ADDR_W-1:0] word_addr(
    input logic [ADDR_W-1:0] base,
    input logic [IDX_W-1:0]  idx
  );
    return base + ADDR_W'(idx);
  endfunction

  assign link_is_head = (link_ptr == head_q);
  assign mem_req      = (state == ST_FETCH);
  assign mem_addr     = word_addr(cur_ptr, word_idx);
  assign word_accept  = mem_req && mem_rvalid;
  assign load_now     = (state == ST_LOAD) && !len_zero;
  assign running      = (state == ST_RUN);
  assign ring_end     = (state == ST_NEXT) && link_is_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_ptr  <= '0;
      head_q   <= '0;
      word_idx <= '0;
      cfg_err  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          head_q   <= head_ptr;
          cur_ptr  <= head_ptr;
          word_idx <= '0;
          cfg_err  <= 1'b0;
          state    <= ST_FETCH;
        end
        ST_FETCH: if (mem_rvalid) begin
          if (word_idx == IDX_W'(DESC_WORDS - 1)) state <= ST_LOAD;
          else word_idx <= word_idx + 1'b1;
        end
        ST_LOAD: begin
          if (len_zero) begin
            cfg_err <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: if (xfer_done) state <= ST_NEXT;
        ST_NEXT: begin
          if (link_is_head) begin
            state <= ST_IDLE;
          end else begin
            cur_ptr  <= link_ptr;
            word_idx <= '0;
            state    <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_desc_loader.sv
module ll_desc_loader
  import ll_desc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ADDR_STEP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_ptr,
  input  logic [ADDR_W-1:0] wrap_addr,
  input  logic [ADDR_W-1:0] wrap_to,
  input  logic [ADDR_W-1:0] xfer_addr,
  output logic [ADDR_W-1:0] xfer_addr_next,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cfg_valid,
  output logic [ADDR_W-1:0] cfg_src,
  output logic [ADDR_W-1:0] cfg_dst,
  output logic [LEN_W-1:0]  cfg_len,
  input  logic              xfer_done,
  output logic              list_done,
  output logic              cfg_err
);
  // Named internal events, visible to the bound checker.
  logic              evt_word_accept;
  logic              evt_load;
  logic [IDX_W-1:0]  word_idx;
  logic [ADDR_W-1:0] link_ptr;
  logic              len_zero;

  ll_fetch_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .head_ptr    (head_ptr),
    .mem_rvalid  (mem_rvalid),
    .xfer_done   (xfer_done),
    .len_zero    (len_zero),
    .link_ptr    (link_ptr),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .word_idx    (word_idx),
    .word_accept (evt_word_accept),
    .load_now    (evt_load),
    .running     (cfg_valid),
    .ring_end    (list_done),
    .cfg_err     (cfg_err)
  );

  ll_desc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .word_accept    (evt_word_accept),
    .word_idx       (word_idx),
    .word_data      (mem_rdata),
    .load_now       (evt_load),
    .stage_link     (link_ptr),
    .stage_len_zero (len_zero),
    .cfg_src        (cfg_src),
    .cfg_dst        (cfg_dst),
    .cfg_len        (cfg_len)
  );

  ll_addr_wrap #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_wrap (
    .cur       (xfer_addr),
    .wrap_at   (wrap_addr),
    .wrap_dest (wrap_to),
    .nxt       (xfer_addr_next)
  );
endmodule

// File: rtl/ll_desc_loader_chk.sv
module ll_desc_loader_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              cfg_valid,
  input logic [ADDR_W-1:0] cfg_src,
  input logic [ADDR_W-1:0] cfg_dst,
  input logic [LEN_W-1:0]  cfg_len,
  input logic              xfer_done,
  input logic              list_done,
  input logic              cfg_err,
  input logic              evt_load
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && mem_req));

  assert_run_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && xfer_done |=> !cfg_valid);

  assert_load_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load |=> cfg_valid);

  assert_ring_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done && !mem_req && !cfg_valid);

  assert_nonzero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> cfg_len != '0);

  assert_err_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !cfg_valid && !mem_req && !list_done);

  assert_cfg_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !xfer_done |=> cfg_valid && $stable(cfg_src)
                                && $stable(cfg_dst) && $stable(cfg_len));
endmodule

bind ll_desc_loader ll_desc_loader_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .cfg_valid  (cfg_valid),
  .cfg_src    (cfg_src),
  .cfg_dst    (cfg_dst),
  .cfg_len    (cfg_len),
  .xfer_done  (xfer_done),
  .list_done  (list_done),
  .cfg_err    (cfg_err),
  .evt_load   (evt_load)
);

// File: tb/ll_desc_loader_tb.sv
module ll_desc_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 16;
  localparam int STEP = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [AW-1:0] head_ptr = '0;
  logic [AW-1:0] wrap_addr = '0, wrap_to = '0, xfer_addr = '0;
  logic [AW-1:0] xfer_addr_next;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 0;
  logic [DW-1:0] mem_rdata = '0;
  logic          cfg_valid;
  logic [AW-1:0] cfg_src, cfg_dst;
  logic [LW-1:0] cfg_len;
  logic          xfer_done = 0;
  logic          list_done;
  logic          cfg_err;

  int n_chk = 0, n_bad = 0, ld_cnt = 0;
  logic [DW-1:0] mem [256];
  logic [AW-1:0] ptrs [8];
  logic [DW-1:0] e_src [8], e_dst [8], e_len [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ll_desc_loader #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .ADDR_STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr),
    .wrap_addr(wrap_addr), .wrap_to(wrap_to), .xfer_addr(xfer_addr),
    .xfer_addr_next(xfer_addr_next), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cfg_valid(cfg_valid),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
    .xfer_done(xfer_done), .list_done(list_done), .cfg_err(cfg_err));

  always @(negedge clk) if (list_done) ld_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_next(input logic [AW-1:0] a, w, t);
    logic [AW:0] sum = {1'b0, a} + (AW+1)'(STEP);
    return (a === w) ? t : sum[AW-1:0];
  endfunction

  // Memory responder: one word per request, random latency, rvalid low between words.
  task automatic mem_model();
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 0;
        wait_cnt = $urandom_range(0, 3);
      end else if (mem_req) begin
        if (wait_cnt == 0) begin
          mem_rvalid = 1;
          mem_rdata  = mem[mem_addr[7:0]];
        end else wait_cnt--;
      end
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] h);
    @(negedge clk); start = 1; head_ptr = h;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  task automatic run_chain(input int n, input int zero_at, input bit stray);
    int slots [64];
    int base;
    for (int i = 0; i < 64; i++) slots[i] = i;
    for (int i = 63; i > 0; i--) begin
      int j = $urandom_range(0, i);
      int t = slots[i]; slots[i] = slots[j]; slots[j] = t;
    end
    for (int i = 0; i < n; i++) ptrs[i] = AW'(slots[i] * 4);
    for (int i = 0; i < n; i++) begin
      e_src[i] = $urandom;
      e_dst[i] = $urandom;
      e_len[i] = {$urandom_range(0, 65535), 16'(0)} | DW'($urandom_range(1, 65535));
      if (i == zero_at) e_len[i] = {16'hABCD, 16'h0000};
      mem[ptrs[i]]     = e_src[i];
      mem[ptrs[i] + 1] = e_dst[i];
      mem[ptrs[i] + 2] = e_len[i];
      mem[ptrs[i] + 3] = {16'h5A5A, ptrs[(i + 1) % n]};
    end
    base = ld_cnt;
    pulse_start(ptrs[0]);
    check("R6 error cleared by start", {31'd0, cfg_err}, 32'd0);
    for (int i = 0; i < n; i++) begin
      int k = 0;
      while (!cfg_valid && !cfg_err && k < 300) begin @(negedge clk); k++; end
      if (i == zero_at) begin
        check("R6 error raised", {31'd0, cfg_err}, 32'd1);
        check("R6 not presented", {31'd0, cfg_valid}, 32'd0);
        repeat (5) @(negedge clk);
        check("R6 halted no read", {31'd0, mem_req}, 32'd0);
        check("R6 no list_done", ld_cnt - base, 32'd0);
        return;
      end
      check("R3 cfg_valid", {31'd0, cfg_valid}, 32'd1);
      check("R2 R3 src", {16'd0, cfg_src}, {16'd0, e_src[i][AW-1:0]});
      check("R2 R3 dst", {16'd0, cfg_dst}, {16'd0, e_dst[i][AW-1:0]});
      check("R2 R3 len", {16'd0, cfg_len}, {16'd0, e_len[i][LW-1:0]});
      check("R4 R5 no early list_done", ld_cnt - base, 32'd0);
      if (stray && i == 0) pulse_start(ptrs[0] ^ 16'h0040);  // R7
      repeat ($urandom_range(0, 4)) @(negedge clk);
      check("R10 src held", {16'd0, cfg_src}, {16'd0, e_src[i][AW-1:0]});
      check("R10 len held", {16'd0, cfg_len}, {16'd0, e_len[i][LW-1:0]});
      pulse_done();
      check("R3 cfg_valid falls", {31'd0, cfg_valid}, 32'd0);
      if (stray) begin @(negedge clk); pulse_done(); end  // R8: outside run
    end
    repeat (3) @(negedge clk);
    check("R5 one list_done", ld_cnt - base, 32'd1);
    check("R5 no read after end", {31'd0, mem_req}, 32'd0);
    check("R5 no cfg after end", {31'd0, cfg_valid}, 32'd0);
  endtask

  initial begin
    fork mem_model(); join_none
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 cfg_valid", {31'd0, cfg_valid}, 32'd0);
    check("R1 list_done", {31'd0, list_done}, 32'd0);
    check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R9 wrap path: directed corners then random.
    wrap_addr = 16'h0100; wrap_to = 16'h0020;
    xfer_addr = 16'h0100; #1 check("R9 at wrap", {16'd0, xfer_addr_next}, 32'h0020);
    xfer_addr = 16'h00FC; #1 check("R9 before wrap", {16'd0, xfer_addr_next}, 32'h0100);
    xfer_addr = 16'hFFFE; #1 check("R9 overflow", {16'd0, xfer_addr_next}, 32'h0002);
    for (int i = 0; i < 20; i++) begin
      xfer_addr = AW'($urandom);
      wrap_addr = (i % 3 == 0) ? xfer_addr : AW'($urandom);
      wrap_to   = AW'($urandom);
      #1 check("R9 random", {16'd0, xfer_addr_next}, {16'd0, exp_next(xfer_addr, wrap_addr, wrap_to)});
    end

    run_chain(1, -1, 0);   // self-linked single descriptor
    run_chain(2, -1, 1);   // stray start / done (R7, R8)
    run_chain(5, -1, 0);
    run_chain(3, 0, 0);    // zero length at head (R6)
    run_chain(4, 2, 1);    // zero length mid-ring (R6)
    run_chain(3, -1, 0);   // error cleared by fresh start
    for (int r = 0; r < 6; r++)
      run_chain($urandom_range(1, 8), -1, r[0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule